// File: doc/BRIEF.md
# Interrupt Pending and Enable Unit

This block collects up to four external interrupt requests for a small microcoded CPU. Each request line gets its own bit in a pending status register. The bit is set on a low-to-high transition of that line, so one button press records one request. The unit also holds a single interrupt-enable flag, and it raises the request line to the CPU only while that flag is set and at least one pending bit is set.

The enable flag drops when the CPU enters a service routine, which prevents nested interrupts. Requests that arrive during servicing are still recorded and are handled once the return-from-interrupt instruction sets the flag again. Service firmware finds the interrupt type by reading the pending register at a decoded I/O address. After it has handled a source, it clears that bit by writing a mask to a second address.

Debouncing and synchronisation of the request lines happen outside this block. Bus accesses need no handshake. A read or write is accepted in the cycle it is presented, so there is no back-pressure. Read data is valid in that same cycle.

Top module: `int_pend_unit`

## Requirements
- R1: After reset, all pending bits are 0 and the enable flag is 1, so `irq` is 0 until a request arrives.
- R2: When `req_in[i]` is first sampled high after having been low, pending bit i is set on that clock edge. A line that stays high does not set its bit again after a clear.
- R3: `irq` is 1 exactly when the enable flag is 1 and at least one pending bit is 1. With the flag set and no bit pending, `irq` is 0.
- R4: A pulse on `isr_enter` clears the enable flag, and `irq` is 0 from the next cycle. Requests that arrive while the flag is clear are still latched.
- R5: A pulse on `isr_return` sets the enable flag. If `isr_enter` and `isr_return` are high in the same cycle, the flag ends up clear.
- R6: While `io_rd` is 1 and `io_addr` equals `STAT_ADDR` (default 0xFC), `io_rdata` shows the pending register in the same cycle, with bit i equal to pending bit i and the upper bits zero. For any other address, or with `io_rd` low, `io_rdata` is 0.
- R7: A write (`io_wr` = 1) to `CLR_ADDR` (default 0xFD) clears each pending bit i for which `io_wdata[i]` is 1. Bits with a 0 in the mask are kept. Writes to any other address leave the pending register unchanged.
- R8: If a new request for bit i and a clear of bit i happen in the same cycle, bit i ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | N_SRC | Debounced external request levels |
| isr_enter | input | 1 | CPU is entering a service routine (one-cycle pulse) |
| isr_return | input | 1 | Return-from-interrupt is executing (one-cycle pulse) |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | DATA_W | I/O write data (clear mask) |
| io_rdata | output | DATA_W | I/O read data (pending status) |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
A request, a clear, `isr_enter` or `isr_return` applied before a rising edge takes effect at that edge. The pending bits and the enable flag update there. `irq` follows combinationally from those registers, and `io_rdata` follows combinationally from the read strobe. Every result is therefore due in the cycle that begins at the edge after the stimulus. The driver changes inputs just after a rising edge and queues its expectations. The monitor compares them at the following falling edge, when both the registered state and the combinational read path have settled.

// File: rtl/int_pend_pkg.sv
package int_pend_pkg;

  // Kind of I/O access seen by the decoder
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_STAT  = 2'd1,
    ACC_CLEAR = 2'd2
  } acc_e;

  localparam int DEF_N_SRC  = 4;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_DATA_W = 4;

endpackage

// File: rtl/ipu_edge_detect.sv
module ipu_edge_detect #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lvl,
  output logic [N_SRC-1:0] rise
);

  logic [N_SRC-1:0] prev_q;

  // One previous-level flop and one rise term per source
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end

endmodule

// File: rtl/ipu_io_decode.sv
module ipu_io_decode
  import int_pend_pkg::*;
#(
  parameter int               N_SRC     = 4,
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hFC,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'hFD
) (
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [N_SRC-1:0]  pend,
  output logic [DATA_W-1:0] io_rdata,
  output logic              clr_en,
  output logic [N_SRC-1:0]  clr_mask
);

  acc_e acc;

  always_comb begin
    acc = ACC_NONE;
    if (io_rd && io_addr == STAT_ADDR)     acc = ACC_STAT;
    else if (io_wr && io_addr == CLR_ADDR) acc = ACC_CLEAR;
  end

  always_comb begin
    io_rdata = '0;
    if (acc == ACC_STAT) begin
      for (int i = 0; i < N_SRC; i++) io_rdata[i] = pend[i];
    end
  end

  assign clr_en = (acc == ACC_CLEAR);

  always_comb begin
    for (int i = 0; i < N_SRC; i++) clr_mask[i] = io_wdata[i];
  end

endmodule

// File: rtl/ipu_pending.sv
module ipu_pending #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rise,
  input  logic             clr_en,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] pend
);

  logic [N_SRC-1:0] kill;

  assign kill = clr_en ? clr_mask : '0;

  // A new request outranks a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~kill) | rise;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> pend[g]); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (kill[g] && !rise[g]) |=> !pend[g]); // R7
    AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (kill[g] && rise[g]) |=> pend[g]); // R8
  end

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && rise == '0) |=> $stable(pend)); // R7

endmodule

// File: rtl/ipu_enable.sv
module ipu_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic isr_enter,
  input  logic isr_return,
  output logic ien
);

  // Entering a service routine takes priority over a return
  always_ff @(posedge clk) begin
    if (!rst_n)          ien <= 1'b1;
    else if (isr_enter)  ien <= 1'b0;
    else if (isr_return) ien <= 1'b1;
  end

  AST_ENTER_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    isr_enter |=> !ien); // R4
  AST_RETURN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_return && !isr_enter) |=> ien); // R5
  AST_EN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!isr_return && !isr_enter) |=> $stable(ien)); // R5

endmodule

// File: rtl/int_pend_unit.sv
module int_pend_unit
  import int_pend_pkg::*;
#(
  parameter int                N_SRC     = DEF_N_SRC,
  parameter int                ADDR_W    = DEF_ADDR_W,
  parameter int                DATA_W    = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hFC,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_in,
  input  logic              isr_enter,
  input  logic              isr_return,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq
);

  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr_mask;
  logic             clr_en;
  logic             ien;

  ipu_edge_detect #(.N_SRC(N_SRC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (req_in),
    .rise (rise)
  );

  ipu_io_decode #(
    .N_SRC    (N_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_ADDR(STAT_ADDR),
    .CLR_ADDR (CLR_ADDR)
  ) u_dec (
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .pend    (pend),
    .io_rdata(io_rdata),
    .clr_en  (clr_en),
    .clr_mask(clr_mask)
  );

  ipu_pending #(.N_SRC(N_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .clr_en  (clr_en),
    .clr_mask(clr_mask),
    .pend    (pend)
  );

  ipu_enable u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .isr_enter (isr_enter),
    .isr_return(isr_return),
    .ien       (ien)
  );

  assign irq = ien & (|pend);

  AST_NO_IRQ_AFTER_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    isr_enter |=> !irq); // R4
  AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rise) && ien && !isr_enter) |=> irq); // R3

endmodule

// File: tb/int_pend_unit_test.sv
module int_pend_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_in = '0;
  logic       isr_enter = 1'b0;
  logic       isr_return = 1'b0;
  logic       io_rd = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic [3:0] io_wdata = '0;
  logic [3:0] io_rdata;
  logic       irq;

  localparam logic [7:0] STAT = 8'hFC;
  localparam logic [7:0] CLR  = 8'hFD;

  always #5 clk = ~clk;

  int_pend_unit uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in),
    .isr_enter(isr_enter), .isr_return(isr_return),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq)
  );

  typedef struct {
    string      req;
    bit         is_irq;
    logic [3:0] exp;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      n_chk++;
      if (it.is_irq) begin
        if (irq !== it.exp[0]) begin
          n_bad++;
          $display("FAIL %s irq actual=%b expected=%b", it.req, irq, it.exp[0]);
        end
      end else begin
        if (io_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s rdata actual=%h expected=%h", it.req, io_rdata, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    isr_enter = 1'b0; isr_return = 1'b0;
    io_rd = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic exp_rd(input string r, input logic [7:0] a, input logic [3:0] v);
    exp_t e;
    io_rd = 1'b1; io_addr = a;
    e.req = r; e.is_irq = 1'b0; e.exp = v;
    q.push_back(e);
  endtask

  task automatic exp_irq(input string r, input logic v);
    exp_t e;
    e.req = r; e.is_irq = 1'b1; e.exp = {3'b000, v};
    q.push_back(e);
  endtask

  task automatic clear(input logic [7:0] a, input logic [3:0] m);
    io_wr = 1'b1; io_addr = a; io_wdata = m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    exp_rd("R1", STAT, 4'b0000);
    exp_irq("R1", 1'b0);

    step(); req_in[0] = 1'b1;
    step();
    exp_rd("R2", STAT, 4'b0001);
    exp_irq("R3", 1'b1);

    step(); clear(CLR, 4'b0001);
    step();
    exp_rd("R7", STAT, 4'b0000);
    exp_irq("R3", 1'b0);
    step();
    exp_rd("R2", STAT, 4'b0000);   // held line does not set again

    step(); req_in[0] = 1'b0;
    isr_enter = 1'b1;
    step(); req_in[2] = 1'b1;
    step(); req_in[2] = 1'b0;
    exp_rd("R4", STAT, 4'b0100);
    exp_irq("R4", 1'b0);

    step(); exp_rd("R6", STAT + 8'd2, 4'b0000);
    step(); io_addr = STAT;          // no read strobe
    begin
      exp_t e; e.req = "R6"; e.is_irq = 1'b0; e.exp = 4'b0000; q.push_back(e);
    end

    step(); clear(CLR + 8'd1, 4'b1111);
    step(); exp_rd("R7", STAT, 4'b0100);

    step(); isr_return = 1'b1;
    step(); exp_irq("R5", 1'b1);
    step(); isr_enter = 1'b1; isr_return = 1'b1;
    step(); exp_irq("R5", 1'b0);

    step(); req_in[1] = 1'b1; clear(CLR, 4'b0110);
    step(); exp_rd("R8", STAT, 4'b0010);

    step(); req_in[3] = 1'b1; req_in[0] = 1'b1;
    step(); exp_rd("R2", STAT, 4'b1011);
    step(); clear(CLR, 4'b1111); isr_return = 1'b1;
    step(); exp_rd("R7", STAT, 4'b0000);
    exp_irq("R3", 1'b0);

    step(); step();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule